// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbitration Scheduler

This block picks the transmit mailbox that a CAN controller sends next. A scan walks the mailboxes one per clock cycle, lowest index first, and keeps a running best candidate. When the walk reaches the last mailbox, that candidate becomes the reported winner. The transmit engine reads the winner index while the winner-valid flag is high. A busy flag covers the whole scan.

A scan can be started in several ways:
- a programmable number of bit times after the protocol engine sees the first CRC bit;
- the same delay after the bus-off recovery counter reaches 124;
- at once when an error or overload delimiter is seen;
- at once when the controller leaves an inactive or power-saving mode;
- by any descriptor control-word write while no scan runs.

Rewriting the control word of the current best candidate, or any start event during a scan, restarts the scan from mailbox 0. A rewrite of the mailbox being examined is remembered. It forces an immediate new scan only if the scan ends without a winner.

Two rules select the winner. In index mode, the lowest-numbered active mailbox wins. In identifier mode, the smallest key wins. The key is the identifier, with the local priority field optionally placed above it. Equal keys go to the lower index.

Top module: `can_txarb_sched`

## Requirements
- R1: After reset, busy_o and win_valid_o are 0.
- R2: A scan with no restart keeps busy_o high for exactly NUM_MB cycles, one mailbox per cycle in ascending index order. win_valid_o rises only at the end of a scan.
- R3: With id_mode_i=0, the winner is the lowest-indexed mailbox whose mb_active_i bit is 1.
- R4: With id_mode_i=1 and prio_en_i=0, the winner is the active mailbox with the smallest identifier (bits [i*ID_W +: ID_W] of mb_id_i). Equal identifiers go to the lower index.
- R5: With id_mode_i=1 and prio_en_i=1, the key is {priority, identifier}. The priority is bits [i*PRIO_W +: PRIO_W] of mb_prio_i and is compared before the identifier.
- R6: After a crc_seen_i pulse with delay value D on start_dly_i, the scan starts on the (D+1)-th following bit_tick_i. busy_o is high in the cycle after that tick. With D=0, the scan starts on the first tick.
- R7: A busoff_124_i pulse starts a scan after the same delay rule as R6.
- R8: A delim_seen_i or wake_i pulse starts a scan in the next cycle. During a scan, such a pulse restarts the scan from mailbox 0.
- R9: A pulse on any bit of mb_wr_i while no scan runs starts a scan in the next cycle.
- R10: A write to the current best candidate during a scan restarts the scan from mailbox 0.
- R11: If the mailbox being examined is written during a scan, what happens at the end depends on the result. With no winner, a new scan starts at once and busy_o stays high. With a winner, the scan finishes normally.
- R12: A scan that finds no active mailbox leaves win_valid_o at 0.
- R13: win_valid_o is 0 whenever busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mb_active_i | input | NUM_MB | Mailbox is pending for transmission |
| mb_id_i | input | NUM_MB*ID_W | Identifiers, mailbox i at [i*ID_W +: ID_W] |
| mb_prio_i | input | NUM_MB*PRIO_W | Local priorities, mailbox i at [i*PRIO_W +: PRIO_W] |
| mb_wr_i | input | NUM_MB | One-cycle control-word write strobe per mailbox |
| id_mode_i | input | 1 | 0: lowest index wins; 1: smallest key wins |
| prio_en_i | input | 1 | Place the local priority above the identifier in the key |
| start_dly_i | input | DLY_W | Start delay in bit times |
| bit_tick_i | input | 1 | One-cycle pulse per CAN bit time |
| crc_seen_i | input | 1 | Pulse: first CRC bit seen on the bus |
| busoff_124_i | input | 1 | Pulse: bus-off recovery counter reached 124 |
| delim_seen_i | input | 1 | Pulse: error or overload delimiter seen |
| wake_i | input | 1 | Pulse: leaving inactive or power-saving mode |
| busy_o | output | 1 | Scan in progress |
| win_valid_o | output | 1 | Winner index is valid |
| win_idx_o | output | $clog2(NUM_MB) | Winning mailbox index |

## Verification
Each winner rule is tried with its own active set.
- Index mode uses a sparse set in which the lowest active index is not mailbox 0.
- Identifier mode uses two equal identifiers that beat a smaller-index mailbox. This separates the tie-break from a plain index pick.
- Enabling the local priority makes the highest identifier win, which shows the priority field really sits above the identifier.

Each start trigger is driven separately, with delays of 0, 1 and 2 bit times, to pin down the exact tick on which the scan begins.

Mid-scan writes cover three cases: the current best candidate, the mailbox under examination with no winner, and the same with a winner present. The busy length shows whether a restart happened.

// File: rtl/can_txarb_pkg.sv
package can_txarb_pkg;
  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/can_txarb_dly.sv
// Bit-time delay between a bus event and the start of a scan.
module can_txarb_dly #(
  parameter int DLY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             tick_i,
  output logic             fire_o
);
  logic             armed_q, armed_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign fire_o  = armed_q & tick_i & at_zero;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (load_i) begin
      armed_d = 1'b1;
      cnt_d   = dly_i;
    end else if (armed_q && tick_i) begin
      if (at_zero) armed_d = 1'b0;
      else         cnt_d   = cnt_q - DLY_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/can_txarb_key.sv
// Per-mailbox comparison key; a zero key turns the scan into a lowest-index pick.
module can_txarb_key #(
  parameter int NUM_MB = 8,
  parameter int ID_W   = 29,
  parameter int PRIO_W = 8,
  localparam int KEY_W = ID_W + PRIO_W
) (
  input  logic [NUM_MB*ID_W-1:0]   id_i,
  input  logic [NUM_MB*PRIO_W-1:0] prio_i,
  input  logic                     id_mode_i,
  input  logic                     prio_en_i,
  output logic [NUM_MB*KEY_W-1:0]  key_o
);
  for (genvar g = 0; g < NUM_MB; g++) begin : g_key
    logic [PRIO_W-1:0] prio_part;
    assign prio_part = prio_en_i ? prio_i[g*PRIO_W +: PRIO_W] : '0;
    assign key_o[g*KEY_W +: KEY_W] =
      id_mode_i ? {prio_part, id_i[g*ID_W +: ID_W]} : '0;
  end
endmodule

// File: rtl/can_txarb_scan.sv
// Ascending one-per-cycle scan with restart handling.
module can_txarb_scan
  import can_txarb_pkg::*;
#(
  parameter int NUM_MB = 8,
  parameter int KEY_W  = 37,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ext_start_i,
  input  logic [NUM_MB-1:0]       active_i,
  input  logic [NUM_MB*KEY_W-1:0] key_i,
  input  logic [NUM_MB-1:0]       wr_i,
  output logic                    busy_o,
  output logic                    win_valid_o,
  output logic [IDX_W-1:0]        win_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_MB - 1);

  scan_st_e         st_q, st_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             tv_q, tv_d;
  logic [IDX_W-1:0] ti_q, ti_d;
  logic [KEY_W-1:0] tk_q, tk_d;
  logic             pend_q, pend_d;
  logic             wv_q, wv_d;
  logic [IDX_W-1:0] wi_q, wi_d;

  logic [KEY_W-1:0] cur_key;
  logic             cur_act, better, best_hit, here_hit, found;

  assign cur_key  = key_i[ptr_q*KEY_W +: KEY_W];
  assign cur_act  = active_i[ptr_q];
  assign better   = cur_act & (~tv_q | (cur_key < tk_q));
  assign best_hit = tv_q & wr_i[ti_q];
  assign here_hit = wr_i[ptr_q];
  assign found    = tv_q | cur_act;

  always_comb begin
    st_d   = st_q;
    ptr_d  = ptr_q;
    tv_d   = tv_q;
    ti_d   = ti_q;
    tk_d   = tk_q;
    pend_d = pend_q;
    wv_d   = wv_q;
    wi_d   = wi_q;
    unique case (st_q)
      SC_IDLE: begin
        if (ext_start_i || (|wr_i)) begin
          st_d   = SC_SCAN;
          ptr_d  = '0;
          tv_d   = 1'b0;
          pend_d = 1'b0;
          wv_d   = 1'b0;
        end
      end
      SC_SCAN: begin
        if (ext_start_i || best_hit) begin
          ptr_d  = '0;
          tv_d   = 1'b0;
          pend_d = 1'b0;
        end else begin
          if (better) begin
            tv_d = 1'b1;
            ti_d = ptr_q;
            tk_d = cur_key;
          end
          if (ptr_q == LAST) begin
            ptr_d = '0;
            if (found) begin
              st_d = SC_IDLE;
              wv_d = 1'b1;
              wi_d = better ? ptr_q : ti_q;
            end else if (pend_q || here_hit) begin
              tv_d   = 1'b0;
              pend_d = 1'b0;
            end else begin
              st_d = SC_IDLE;
            end
          end else begin
            ptr_d  = ptr_q + IDX_W'(1);
            pend_d = pend_q | here_hit;
          end
        end
      end
      default: st_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SC_IDLE;
      ptr_q  <= '0;
      tv_q   <= 1'b0;
      ti_q   <= '0;
      tk_q   <= '0;
      pend_q <= 1'b0;
      wv_q   <= 1'b0;
      wi_q   <= '0;
    end else begin
      st_q   <= st_d;
      ptr_q  <= ptr_d;
      tv_q   <= tv_d;
      ti_q   <= ti_d;
      tk_q   <= tk_d;
      pend_q <= pend_d;
      wv_q   <= wv_d;
      wi_q   <= wi_d;
    end
  end

  assign busy_o      = (st_q == SC_SCAN);
  assign win_valid_o = wv_q;
  assign win_idx_o   = wi_q;
endmodule

// File: rtl/can_txarb_sched.sv
module can_txarb_sched #(
  parameter int NUM_MB = 8,
  parameter int ID_W   = 29,
  parameter int PRIO_W = 8,
  parameter int DLY_W  = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_MB-1:0]          mb_active_i,
  input  logic [NUM_MB*ID_W-1:0]     mb_id_i,
  input  logic [NUM_MB*PRIO_W-1:0]   mb_prio_i,
  input  logic [NUM_MB-1:0]          mb_wr_i,
  input  logic                       id_mode_i,
  input  logic                       prio_en_i,
  input  logic [DLY_W-1:0]           start_dly_i,
  input  logic                       bit_tick_i,
  input  logic                       crc_seen_i,
  input  logic                       busoff_124_i,
  input  logic                       delim_seen_i,
  input  logic                       wake_i,
  output logic                       busy_o,
  output logic                       win_valid_o,
  output logic [$clog2(NUM_MB)-1:0]  win_idx_o
);
  localparam int KEY_W = ID_W + PRIO_W;

  logic [NUM_MB*KEY_W-1:0] keys;
  logic                    dly_fire;
  logic                    ext_start;

  can_txarb_dly #(.DLY_W(DLY_W)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (crc_seen_i | busoff_124_i),
    .dly_i  (start_dly_i),
    .tick_i (bit_tick_i),
    .fire_o (dly_fire)
  );

  can_txarb_key #(.NUM_MB(NUM_MB), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_key (
    .id_i      (mb_id_i),
    .prio_i    (mb_prio_i),
    .id_mode_i (id_mode_i),
    .prio_en_i (prio_en_i),
    .key_o     (keys)
  );

  assign ext_start = dly_fire | delim_seen_i | wake_i;

  can_txarb_scan #(.NUM_MB(NUM_MB), .KEY_W(KEY_W)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ext_start_i (ext_start),
    .active_i    (mb_active_i),
    .key_i       (keys),
    .wr_i        (mb_wr_i),
    .busy_o      (busy_o),
    .win_valid_o (win_valid_o),
    .win_idx_o   (win_idx_o)
  );
endmodule

// File: rtl/can_txarb_sched_chk.sv
module can_txarb_sched_chk #(
  parameter int NUM_MB = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              win_valid_o,
  input logic [NUM_MB-1:0] mb_wr_i,
  input logic              delim_seen_i,
  input logic              wake_i
);
  // R13
  busy_hides_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !win_valid_o);

  // R2
  valid_after_scan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_valid_o) |-> $past(busy_o));

  // R8
  delim_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (delim_seen_i && !busy_o) |=> busy_o);

  // R8
  wake_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !busy_o) |=> busy_o);

  // R9
  idle_write_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (|mb_wr_i)) |=> busy_o);
endmodule

bind can_txarb_sched can_txarb_sched_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .win_valid_o  (win_valid_o),
  .mb_wr_i      (mb_wr_i),
  .delim_seen_i (delim_seen_i),
  .wake_i       (wake_i)
);

// File: tb/can_txarb_sched_test.sv
module can_txarb_sched_test;
  localparam int NMB = 8;
  localparam int IW  = 29;
  localparam int PW  = 8;
  localparam int DW  = 5;
  localparam int XW  = $clog2(NMB);

  logic            clk, rst_n;
  logic [NMB-1:0]  act, wr;
  logic [NMB*IW-1:0] ids;
  logic [NMB*PW-1:0] prios;
  logic            idm, pen, tick, crc, boff, delim, wake;
  logic [DW-1:0]   dly;
  logic            busy, wvld;
  logic [XW-1:0]   widx;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  vld;
    int    idx;
    int    len;
    string tag;
  } exp_t;
  exp_t sb[$];

  can_txarb_sched #(.NUM_MB(NMB), .ID_W(IW), .PRIO_W(PW), .DLY_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mb_active_i(act), .mb_id_i(ids),
    .mb_prio_i(prios), .mb_wr_i(wr), .id_mode_i(idm), .prio_en_i(pen),
    .start_dly_i(dly), .bit_tick_i(tick), .crc_seen_i(crc),
    .busoff_124_i(boff), .delim_seen_i(delim), .wake_i(wake),
    .busy_o(busy), .win_valid_o(wvld), .win_idx_o(widx));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // Reference winner from the requirements (R3, R4, R5).
  task automatic push_exp(input string tag, input int len);
    exp_t e;
    logic [PW+IW-1:0] best, k;
    e.vld = 1'b0; e.idx = 0; e.len = len; e.tag = tag;
    best = '0;
    for (int i = 0; i < NMB; i++) begin
      if (act[i]) begin
        k = idm ? {(pen ? prios[i*PW +: PW] : {PW{1'b0}}), ids[i*IW +: IW]} : '0;
        if (!e.vld || k < best) begin
          e.vld = 1'b1; e.idx = i; best = k;
        end
      end
    end
    sb.push_back(e);
  endtask

  // Monitor: counts busy cycles and compares the result at the end of a scan.
  int blen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        blen++;
        check(!wvld, "R13", $sformatf("win_valid=%0b during scan, exp 0", wvld));
      end else if (blen > 0) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2", "scan ended with no expected item");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(blen == e.len, e.tag,
                $sformatf("busy length act=%0d exp=%0d", blen, e.len));
          check(wvld == e.vld, e.tag,
                $sformatf("win_valid act=%0b exp=%0b", wvld, e.vld));
          if (e.vld)
            check(int'(widx) == e.idx, e.tag,
                  $sformatf("win_idx act=%0d exp=%0d", widx, e.idx));
        end
        blen = 0;
      end
    end
  end

  task automatic set_id(input int i, input int v);
    ids[i*IW +: IW] = IW'(v);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "WDOG", "watchdog expired, act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; act = '0; wr = '0; ids = '0; prios = '0;
    idm = 1'b0; pen = 1'b0; tick = 1'b0; crc = 1'b0; boff = 1'b0;
    delim = 1'b0; wake = 1'b0; dly = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !wvld, "R1", $sformatf("busy=%0b valid=%0b exp 0/0", busy, wvld));

    // R3 + R9: index mode, start by an idle write.
    act = 8'b0110_1000;
    push_exp("R3", NMB);
    @(negedge clk) wr[5] = 1'b1;
    @(negedge clk) wr[5] = 1'b0;
    check(busy, "R9", $sformatf("busy=%0b after idle write, exp 1", busy));
    wait_idle();

    // R4 + R8: identifier mode with a tie, start by delimiter.
    idm = 1'b1; act = 8'b0101_0010;
    set_id(1, 'h300); set_id(4, 'h100); set_id(6, 'h100);
    push_exp("R4", NMB);
    @(negedge clk) delim = 1'b1;
    @(negedge clk) delim = 1'b0;
    check(busy, "R8", $sformatf("busy=%0b after delimiter, exp 1", busy));
    wait_idle();

    // R5 + R8: local priority above identifier, start by wake.
    pen = 1'b1;
    prios[1*PW +: PW] = 8'd0; prios[4*PW +: PW] = 8'd3; prios[6*PW +: PW] = 8'd3;
    push_exp("R5", NMB);
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    check(busy, "R8", $sformatf("busy=%0b after wake, exp 1", busy));
    wait_idle();

    // R12: nothing active.
    act = '0;
    push_exp("R12", NMB);
    @(negedge clk) delim = 1'b1;
    @(negedge clk) delim = 1'b0;
    wait_idle();

    // R6: CRC trigger with delay 2 starts on the third tick.
    act = 8'b0001_0000; idm = 1'b0; pen = 1'b0; dly = 5'd2;
    push_exp("R6", NMB);
    @(negedge clk) crc = 1'b1;
    @(negedge clk) crc = 1'b0;
    do_tick();
    do_tick();
    check(!busy, "R6", $sformatf("busy=%0b after 2 ticks with delay 2, exp 0", busy));
    do_tick();
    check(busy, "R6", $sformatf("busy=%0b after 3 ticks with delay 2, exp 1", busy));
    wait_idle();

    // R6: delay 0 starts on the first tick.
    dly = 5'd0;
    push_exp("R6", NMB);
    @(negedge clk) crc = 1'b1;
    @(negedge clk) crc = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy, "R6", $sformatf("busy=%0b before any tick, exp 0", busy));
    do_tick();
    check(busy, "R6", $sformatf("busy=%0b after 1 tick with delay 0, exp 1", busy));
    wait_idle();

    // R7: bus-off trigger with delay 1 starts on the second tick.
    dly = 5'd1;
    push_exp("R7", NMB);
    @(negedge clk) boff = 1'b1;
    @(negedge clk) boff = 1'b0;
    do_tick();
    check(!busy, "R7", $sformatf("busy=%0b after 1 tick with delay 1, exp 0", busy));
    do_tick();
    check(busy, "R7", $sformatf("busy=%0b after 2 ticks with delay 1, exp 1", busy));
    wait_idle();

    // R10: write to the best candidate mid-scan restarts: 4 + 8 busy cycles.
    act = 8'b0010_0100;
    push_exp("R10", 4 + NMB);
    @(negedge clk) delim = 1'b1;
    @(negedge clk) delim = 1'b0;
    repeat (3) @(negedge clk);
    wr[2] = 1'b1;
    @(negedge clk) wr[2] = 1'b0;
    wait_idle();

    // R11: scanned mailbox written, no winner: immediate rescan, 16 cycles.
    act = '0;
    @(negedge clk) delim = 1'b1;
    @(negedge clk) delim = 1'b0;
    repeat (3) @(negedge clk);
    wr[3] = 1'b1;
    @(negedge clk) begin wr[3] = 1'b0; act[3] = 1'b1; end
    push_exp("R11", 2 * NMB);
    wait_idle();

    // R11: scanned mailbox written, winner present: scan finishes, 8 cycles.
    act = 8'b0000_0010;
    push_exp("R11", NMB);
    @(negedge clk) delim = 1'b1;
    @(negedge clk) delim = 1'b0;
    repeat (4) @(negedge clk);
    wr[4] = 1'b1;
    @(negedge clk) wr[4] = 1'b0;
    wait_idle();

    repeat (2) @(negedge clk);
    check(sb.size() == 0, "R2", $sformatf("pending items act=%0d exp=0", sb.size()));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule